// File: doc/BRIEF.md
# MMIO to Sideband Register Bridge

The bridge sits between a host memory-mapped port and a sideband register network inside one chip. The host issues 64-bit reads and writes into a window reserved for this chip. The bridge checks that each access is legal and folds the host offset into a compact sideband register address. A small set of housekeeping registers is answered on the spot. Every other access goes to the first attached target slot that claims the address, together with the index of the claiming range and the offset inside it.

Each slot describes up to four address ranges as base and size pairs, supplied on configuration inputs. A size of zero marks a range as unused. The host uses a valid/ready handshake and only one access is in flight at a time. The host port stays blocked from acceptance until the response pulse. Each response carries a done flag, plus a fail flag for accesses that were refused, missed every target or were rejected by the target.

Top module: `mmio_sideband_bridge`

## Requirements
- R1: An access is in the window only when host_addr lies in [0x3fc0000000000 + chip_sel*0x800000000, that base + 0x800000000). An access outside it completes with done=1, fail=1, rdata=0 and raises no target request.
- R2: An access whose host_size is not 8 completes with done=1, fail=1, rdata=0 and raises no target request.
- R3: The sideband address is built from the 35-bit window offset W: bits [30:4] come from W[34:8] and bits [3:0] from W[6:3]. W[7] and W[2:0] do not affect it. Write data and read data pass through unchanged as one 64-bit word.
- R4: A read of sideband address 0xF000F returns the parameter ID_VALUE with done=1, fail=0. A write to 0xF000F is acknowledged but changes nothing. Neither is forwarded.
- R5: Reads of 0x1010C00, 0x1010C03, 0x2020007, 0x2020009, 0x202000F and 0x2013F00 to 0x2013F07 return 0 with done=1, fail=0 and are not forwarded.
- R6: Writes to 0x1010C00 to 0x1010C05, 0x2020007, 0x2020009 and 0x202000F are acknowledged with done=1, fail=0 and discarded. A read of 0x1010C01 or a write to 0x2013F00 is not intercepted and is dispatched.
- R7: Range r of slot s claims address A when size != 0 and base <= A < base + size. The target gets tgt_range = r and tgt_offset = A - base.
- R8: When several ranges claim an address, the lowest slot wins, and within that slot the lowest range wins.
- R9: An address that no range claims completes with done=1, fail=1, rdata=0.
- R10: A target nack completes with done=1, fail=1, rdata=0. An ack completes with done=1, fail=0. For a read, rdata is that slot's tgt_rdata word.
- R11: From acceptance until the response, host_ready is low. At most one tgt_req bit is set, and it holds steady until that slot acks or nacks.
- R12: Local, refused and missed accesses respond in the cycle after acceptance. A dispatched access raises tgt_req in the cycle after acceptance and responds in the cycle after the ack or nack is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel | input | CHIP_W | Chip number that places the window |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Bridge can accept an access |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | HADDR_W | Host byte address |
| host_size | input | 4 | Access width in bytes |
| host_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_done | output | 1 | Completion flag |
| rsp_fail | output | 1 | Failure flag |
| rsp_rdata | output | DATA_W | Read data |
| tgt_base | input | N_SLOTS*N_RANGES*SB_W | Range bases, entry s*N_RANGES+r |
| tgt_size | input | N_SLOTS*N_RANGES*SB_W | Range sizes, same layout |
| tgt_req | output | N_SLOTS | One-hot request to the claiming slot |
| tgt_write | output | 1 | Direction of the dispatched access |
| tgt_range | output | RNG_W | Index of the claiming range |
| tgt_offset | output | SB_W | Offset inside the claiming range |
| tgt_wdata | output | DATA_W | Dispatched write data |
| tgt_ack | input | N_SLOTS | Per-slot accept |
| tgt_nack | input | N_SLOTS | Per-slot reject |
| tgt_rdata | input | N_SLOTS*DATA_W | Per-slot read data |

## Verification
The host request is accepted at one rising edge. For local, refused and missed accesses, rsp_valid shows in the very next cycle. For a dispatched access, tgt_req shows in the next cycle, and rsp_valid follows one cycle after the edge that samples the ack or nack. Each scenario drives its inputs on falling edges, counts the falling edges from acceptance to the response pulse and compares that count with 1, or with 2 plus the target's delay. Request fields and host_ready are sampled on falling edges while the request is open.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_BUSY} sbb_state_e;

  typedef struct packed {
    logic done;
    logic fail;
  } sbb_status_t;
endpackage

// File: rtl/sbb_xlate.sv
// Window check and host-offset to sideband-address folding.
module sbb_xlate #(
  parameter int HADDR_W = 50,
  parameter int WIN_LOG2 = 35,
  parameter int CHIP_W = 6,
  parameter int SB_W = 32,
  parameter int unsigned WIN_BASE_TAG = 'h7f80
) (
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [CHIP_W-1:0]  chip_sel,
  output logic               in_window,
  output logic [SB_W-1:0]    sb_addr
);
  localparam int TAG_W = HADDR_W - WIN_LOG2;

  logic [TAG_W-1:0]    tag;
  logic [WIN_LOG2-1:0] off;
  logic                unused_off_bits;

  assign tag = host_addr[HADDR_W-1:WIN_LOG2];
  assign off = host_addr[WIN_LOG2-1:0];

  assign in_window = (tag == (TAG_W'(WIN_BASE_TAG) + TAG_W'(chip_sel)));
  // upper part shifted by four with low nibble cleared, low nibble from offset/8
  assign sb_addr = SB_W'({off[WIN_LOG2-1:8], off[6:3]});
  assign unused_off_bits = ^{off[7], off[2:0]};
endmodule

// File: rtl/sbb_local.sv
// Housekeeping registers answered without dispatch.
module sbb_local #(
  parameter int SB_W = 32,
  parameter int DATA_W = 64,
  parameter logic [63:0] ID_VALUE = 64'h00C0_FFEE_0000_A5A5
) (
  input  logic [SB_W-1:0]   sb_addr,
  input  logic              is_write,
  output logic              hit,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [SB_W-1:0] A_ID     = SB_W'(32'h000F_000F);
  localparam logic [SB_W-1:0] A_FIR_LO = SB_W'(32'h0101_0C00);
  localparam logic [SB_W-1:0] A_FIR_MK = SB_W'(32'h0101_0C03);
  localparam logic [SB_W-1:0] A_FIR_HI = SB_W'(32'h0101_0C05);
  localparam logic [SB_W-1:0] A_ADU_7  = SB_W'(32'h0202_0007);
  localparam logic [SB_W-1:0] A_ADU_9  = SB_W'(32'h0202_0009);
  localparam logic [SB_W-1:0] A_ADU_F  = SB_W'(32'h0202_000F);
  localparam logic [SB_W-4:0] A_BLK8   = (SB_W-3)'(32'h0201_3F00 >> 3);

  logic adu_hit;
  assign adu_hit = (sb_addr == A_ADU_7) || (sb_addr == A_ADU_9) || (sb_addr == A_ADU_F);

  always_comb begin
    hit   = 1'b0;
    rdata = '0;
    if (is_write) begin
      if ((sb_addr == A_ID) || adu_hit ||
          ((sb_addr >= A_FIR_LO) && (sb_addr <= A_FIR_HI)))
        hit = 1'b1;
    end else begin
      if (sb_addr == A_ID) begin
        hit   = 1'b1;
        rdata = DATA_W'(ID_VALUE);
      end else if ((sb_addr == A_FIR_LO) || (sb_addr == A_FIR_MK) || adu_hit ||
                   (sb_addr[SB_W-1:3] == A_BLK8)) begin
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbb_match.sv
// Priority range matcher: lowest slot, then lowest range.
module sbb_match #(
  parameter int N_SLOTS = 3,
  parameter int N_RANGES = 4,
  parameter int SB_W = 32,
  parameter int SLOT_W = 2,
  parameter int RNG_W = 2
) (
  input  logic [SB_W-1:0]                  sb_addr,
  input  logic [N_SLOTS*N_RANGES*SB_W-1:0] rng_base,
  input  logic [N_SLOTS*N_RANGES*SB_W-1:0] rng_size,
  output logic                             hit,
  output logic [SLOT_W-1:0]                slot,
  output logic [RNG_W-1:0]                 rng,
  output logic [SB_W-1:0]                  offset
);
  localparam int N_ENT = N_SLOTS * N_RANGES;

  logic [N_ENT-1:0] claim;
  logic [SB_W-1:0]  delta [N_ENT];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    for (genvar r = 0; r < N_RANGES; r++) begin : g_rng
      localparam int K = s * N_RANGES + r;
      logic [SB_W-1:0] base_k, size_k;
      assign base_k   = rng_base[K*SB_W +: SB_W];
      assign size_k   = rng_size[K*SB_W +: SB_W];
      assign delta[K] = sb_addr - base_k;
      assign claim[K] = (size_k != '0) && (sb_addr >= base_k) && (delta[K] < size_k);
    end
  end

  always_comb begin
    hit    = 1'b0;
    slot   = '0;
    rng    = '0;
    offset = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (claim[k]) begin
        hit    = 1'b1;
        slot   = SLOT_W'(k / N_RANGES);
        rng    = RNG_W'(k % N_RANGES);
        offset = delta[k];
      end
    end
  end
endmodule

// File: rtl/mmio_sideband_bridge.sv
module mmio_sideband_bridge
  import sbb_pkg::*;
#(
  parameter int N_SLOTS = 3,
  parameter int N_RANGES = 4,
  parameter int CHIP_W = 6,
  parameter int HADDR_W = 50,
  parameter int WIN_LOG2 = 35,
  parameter int SB_W = 32,
  parameter int DATA_W = 64,
  parameter int unsigned WIN_BASE_TAG = 'h7f80,
  parameter logic [63:0] ID_VALUE = 64'h00C0_FFEE_0000_A5A5,
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int RNG_W = (N_RANGES > 1) ? $clog2(N_RANGES) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [CHIP_W-1:0]                chip_sel,
  input  logic                             host_valid,
  output logic                             host_ready,
  input  logic                             host_write,
  input  logic [HADDR_W-1:0]               host_addr,
  input  logic [3:0]                       host_size,
  input  logic [DATA_W-1:0]                host_wdata,
  output logic                             rsp_valid,
  output logic                             rsp_done,
  output logic                             rsp_fail,
  output logic [DATA_W-1:0]                rsp_rdata,
  input  logic [N_SLOTS*N_RANGES*SB_W-1:0] tgt_base,
  input  logic [N_SLOTS*N_RANGES*SB_W-1:0] tgt_size,
  output logic [N_SLOTS-1:0]               tgt_req,
  output logic                             tgt_write,
  output logic [RNG_W-1:0]                 tgt_range,
  output logic [SB_W-1:0]                  tgt_offset,
  output logic [DATA_W-1:0]                tgt_wdata,
  input  logic [N_SLOTS-1:0]               tgt_ack,
  input  logic [N_SLOTS-1:0]               tgt_nack,
  input  logic [N_SLOTS*DATA_W-1:0]        tgt_rdata
);
  localparam int ACC_BYTES = DATA_W / 8;

  sbb_state_e       state;
  sbb_status_t      status_q;
  logic [SLOT_W-1:0] busy_slot;

  logic              in_win, loc_hit, m_hit, size_ok, accept;
  logic [SB_W-1:0]   sb_addr, m_off;
  logic [DATA_W-1:0] loc_data, sel_rdata;
  logic [SLOT_W-1:0] m_slot;
  logic [RNG_W-1:0]  m_rng;
  logic              sel_ack, sel_nack;

  sbb_xlate #(
    .HADDR_W(HADDR_W), .WIN_LOG2(WIN_LOG2), .CHIP_W(CHIP_W),
    .SB_W(SB_W), .WIN_BASE_TAG(WIN_BASE_TAG)
  ) u_xlate (
    .host_addr(host_addr), .chip_sel(chip_sel),
    .in_window(in_win), .sb_addr(sb_addr)
  );

  sbb_local #(.SB_W(SB_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_local (
    .sb_addr(sb_addr), .is_write(host_write), .hit(loc_hit), .rdata(loc_data)
  );

  sbb_match #(
    .N_SLOTS(N_SLOTS), .N_RANGES(N_RANGES), .SB_W(SB_W),
    .SLOT_W(SLOT_W), .RNG_W(RNG_W)
  ) u_match (
    .sb_addr(sb_addr), .rng_base(tgt_base), .rng_size(tgt_size),
    .hit(m_hit), .slot(m_slot), .rng(m_rng), .offset(m_off)
  );

  assign host_ready = (state == ST_IDLE);
  assign accept     = host_valid && host_ready;
  assign size_ok    = (host_size == 4'(ACC_BYTES));
  assign sel_ack    = tgt_ack[busy_slot];
  assign sel_nack   = tgt_nack[busy_slot];
  assign sel_rdata  = tgt_rdata[busy_slot*DATA_W +: DATA_W];
  assign rsp_done   = status_q.done;
  assign rsp_fail   = status_q.fail;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      status_q   <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      busy_slot  <= '0;
      tgt_req    <= '0;
      tgt_write  <= 1'b0;
      tgt_range  <= '0;
      tgt_offset <= '0;
      tgt_wdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      status_q  <= '0;
      rsp_rdata <= '0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!size_ok || !in_win) begin
              rsp_valid <= 1'b1;
              status_q  <= '{done: 1'b1, fail: 1'b1};
            end else if (loc_hit) begin
              rsp_valid <= 1'b1;
              status_q  <= '{done: 1'b1, fail: 1'b0};
              rsp_rdata <= loc_data;
            end else if (m_hit) begin
              state      <= ST_BUSY;
              busy_slot  <= m_slot;
              tgt_req    <= N_SLOTS'(1) << m_slot;
              tgt_write  <= host_write;
              tgt_range  <= m_rng;
              tgt_offset <= m_off;
              tgt_wdata  <= host_wdata;
            end else begin
              rsp_valid <= 1'b1;
              status_q  <= '{done: 1'b1, fail: 1'b1};
            end
          end
        end
        ST_BUSY: begin
          if (sel_ack || sel_nack) begin
            state     <= ST_IDLE;
            tgt_req   <= '0;
            rsp_valid <= 1'b1;
            status_q  <= '{done: 1'b1, fail: !sel_ack};
            if (sel_ack && !tgt_write)
              rsp_rdata <= sel_rdata;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
  parameter int N_SLOTS = 3,
  parameter int DATA_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               host_valid,
  input logic               host_ready,
  input logic [3:0]         host_size,
  input logic               rsp_valid,
  input logic               rsp_done,
  input logic               rsp_fail,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic [N_SLOTS-1:0] tgt_req,
  input logic [N_SLOTS-1:0] tgt_ack,
  input logic [N_SLOTS-1:0] tgt_nack
);
  localparam logic [3:0] ACC_BYTES = 4'(DATA_W / 8);

  p_fail_has_done_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_fail |-> (rsp_done && rsp_valid));

  p_resp_done_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_done);

  p_fail_zero_data_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fail) |-> (rsp_rdata == '0));

  p_single_req_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_req));

  p_busy_blocks_host_r11: assert property (@(posedge clk) disable iff (rst)
    (tgt_req != '0) |-> !host_ready);

  p_req_held_r11: assert property (@(posedge clk) disable iff (rst)
    ((tgt_req != '0) && (((tgt_ack | tgt_nack) & tgt_req) == '0)) |=> (tgt_req == $past(tgt_req)));

  p_bad_size_r2: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_ready && (host_size != ACC_BYTES)) |=> (rsp_valid && rsp_fail && (tgt_req == '0)));

  p_answer_closes_r12: assert property (@(posedge clk) disable iff (rst)
    (((tgt_ack | tgt_nack) & tgt_req) != '0) |=> (rsp_valid && (tgt_req == '0)));
endmodule

bind mmio_sideband_bridge sbb_checker #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W)) i_sbb_checker (
  .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
  .host_size(host_size), .rsp_valid(rsp_valid), .rsp_done(rsp_done),
  .rsp_fail(rsp_fail), .rsp_rdata(rsp_rdata), .tgt_req(tgt_req),
  .tgt_ack(tgt_ack), .tgt_nack(tgt_nack)
);

// File: tb/test_mmio_sideband_bridge.sv
`timescale 1ns/1ps
module test_mmio_sideband_bridge;
  localparam int NS = 3;
  localparam int NR = 4;
  localparam logic [63:0] ID_V = 64'h00C0_FFEE_0000_A5A5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] chip_sel = 6'd2;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic host_ready;
  logic [49:0] host_addr = '0;
  logic [3:0] host_size = 4'd8;
  logic [63:0] host_wdata = '0;
  logic rsp_valid, rsp_done, rsp_fail;
  logic [63:0] rsp_rdata;
  logic [NS*NR*32-1:0] tgt_base = '0, tgt_size = '0;
  logic [NS-1:0] tgt_req;
  logic tgt_write;
  logic [1:0] tgt_range;
  logic [31:0] tgt_offset;
  logic [63:0] tgt_wdata;
  logic [NS-1:0] tgt_ack = '0, tgt_nack = '0;
  logic [NS*64-1:0] tgt_rdata = '0;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [63:0] r_data;
  logic r_done, r_fail, r_req, r_wr, r_held_bad, r_ready_bad;
  int r_cyc, r_slot;
  logic [1:0] r_rng;
  logic [31:0] r_off;
  logic [63:0] r_wd;

  always #10 clk = ~clk;

  mmio_sideband_bridge #(.N_SLOTS(NS), .N_RANGES(NR), .ID_VALUE(ID_V)) i_mmio_sideband_bridge (
    .clk(clk), .rst(rst), .chip_sel(chip_sel), .host_valid(host_valid),
    .host_ready(host_ready), .host_write(host_write), .host_addr(host_addr),
    .host_size(host_size), .host_wdata(host_wdata), .rsp_valid(rsp_valid),
    .rsp_done(rsp_done), .rsp_fail(rsp_fail), .rsp_rdata(rsp_rdata),
    .tgt_base(tgt_base), .tgt_size(tgt_size), .tgt_req(tgt_req),
    .tgt_write(tgt_write), .tgt_range(tgt_range), .tgt_offset(tgt_offset),
    .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack), .tgt_nack(tgt_nack),
    .tgt_rdata(tgt_rdata)
  );

  function automatic logic [49:0] haddr(input int chip, input logic [31:0] sb);
    return 50'h3fc0000000000 + 50'(chip) * 50'h800000000 +
           (50'(sb >> 4) << 8) + (50'(sb & 32'hF) << 3);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_rng(input int s, input int r, input logic [31:0] b, input logic [31:0] sz);
    tgt_base[(s*NR+r)*32 +: 32] = b;
    tgt_size[(s*NR+r)*32 +: 32] = sz;
  endtask

  task automatic acc(input bit wr, input logic [49:0] a, input logic [3:0] sz,
                     input logic [63:0] wd, input bit nak, input int dly,
                     input logic [63:0] rv);
    int waitc;
    logic [NS-1:0] prev;
    @(negedge clk);
    host_write = wr; host_addr = a; host_size = sz; host_wdata = wd; host_valid = 1'b1;
    for (int s = 0; s < NS; s++) tgt_rdata[s*64 +: 64] = rv + 64'(s);
    r_req = 1'b0; r_held_bad = 1'b0; r_ready_bad = 1'b0; r_slot = -1; waitc = 0; prev = '0;
    r_rng = '0; r_off = '0; r_wd = '0; r_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    r_cyc = 1;
    while (!rsp_valid && r_cyc < 40) begin
      if (tgt_req != '0) begin
        if (!r_req) begin
          r_req = 1'b1; prev = tgt_req;
          for (int s = 0; s < NS; s++) if (tgt_req[s]) r_slot = s;
          r_rng = tgt_range; r_off = tgt_offset; r_wd = tgt_wdata; r_wr = tgt_write;
        end else if (tgt_req != prev) r_held_bad = 1'b1;
        if (host_ready) r_ready_bad = 1'b1;
        if (waitc >= dly) begin
          if (nak) tgt_nack = tgt_req; else tgt_ack = tgt_req;
        end
        waitc++;
      end
      @(negedge clk);
      tgt_ack = '0; tgt_nack = '0;
      r_cyc++;
    end
    r_data = rsp_rdata; r_done = rsp_done; r_fail = rsp_fail;
  endtask

  task automatic exp_local(input string tag, input logic [63:0] d, input bit f);
    chk({tag, " no dispatch"}, 64'(r_req), 64'(0));
    chk({tag, " latency"}, 64'(r_cyc), 64'(1));
    chk({tag, " done"}, 64'(r_done), 64'(1));
    chk({tag, " fail"}, 64'(r_fail), 64'(f));
    chk({tag, " data"}, r_data, d);
  endtask

  task automatic exp_tgt(input string tag, input int s, input int r, input logic [31:0] o);
    chk({tag, " dispatched"}, 64'(r_req), 64'(1));
    chk({tag, " slot"}, 64'(r_slot), 64'(s));
    chk({tag, " range"}, 64'(r_rng), 64'(r));
    chk({tag, " offset"}, 64'(r_off), 64'(o));
  endtask

  task automatic t_reset;
    chk("R11 reset ready", 64'(host_ready), 64'(1));
    chk("R11 reset no req", 64'(tgt_req), 64'(0));
    chk("R12 reset no rsp", 64'(rsp_valid), 64'(0));
  endtask

  task automatic t_id;
    acc(0, haddr(2, 32'hF000F), 4'd8, 0, 0, 0, 64'h0);
    exp_local("R4 id read", ID_V, 0);
    acc(1, haddr(2, 32'hF000F), 4'd8, 64'h1111_2222_3333_4444, 0, 0, 64'h0);
    exp_local("R4 id write", 64'h0, 0);
    acc(0, haddr(2, 32'hF000F), 4'd8, 0, 0, 0, 64'h0);
    exp_local("R4 id after write", ID_V, 0);
  endtask

  task automatic t_zero_reads;
    logic [31:0] lst [5] = '{32'h1010C00, 32'h1010C03, 32'h2020007, 32'h2020009, 32'h202000F};
    foreach (lst[i]) begin
      acc(0, haddr(2, lst[i]), 4'd8, 0, 0, 0, 64'hAAAA);
      exp_local("R5 zero read", 64'h0, 0);
    end
    for (int k = 0; k < 8; k++) begin
      acc(0, haddr(2, 32'h2013F00 + 32'(k)), 4'd8, 0, 0, 0, 64'hAAAA);
      exp_local("R5 block read", 64'h0, 0);
    end
  endtask

  task automatic t_discard_writes;
    logic [31:0] lst [3] = '{32'h2020007, 32'h2020009, 32'h202000F};
    for (int k = 0; k < 6; k++) begin
      acc(1, haddr(2, 32'h1010C00 + 32'(k)), 4'd8, 64'h5, 0, 0, 64'h0);
      exp_local("R6 discard write", 64'h0, 0);
    end
    foreach (lst[i]) begin
      acc(1, haddr(2, lst[i]), 4'd8, 64'h6, 0, 0, 64'h0);
      exp_local("R6 discard adu write", 64'h0, 0);
    end
    acc(0, haddr(2, 32'h1010C01), 4'd8, 0, 0, 0, 64'h7700);
    exp_tgt("R6 read 1010C01 forwarded", 0, 3, 32'h1);
    chk("R6 read 1010C01 data", r_data, 64'h7700);
    acc(1, haddr(2, 32'h2013F00), 4'd8, 64'hBEEF, 0, 0, 64'h0);
    exp_tgt("R6 write 2013F00 forwarded", 0, 2, 32'h0);
  endtask

  task automatic t_xlate;
    acc(0, haddr(2, 32'h100003), 4'd8, 0, 0, 0, 64'h0123_4567_89AB_CDEF);
    exp_tgt("R3 plain", 0, 0, 32'h3);
    chk("R3 read data", r_data, 64'h0123_4567_89AB_CDEF);
    chk("R12 dispatch latency", 64'(r_cyc), 64'(2));
    chk("R10 ack not fail", 64'(r_fail), 64'(0));
    acc(0, haddr(2, 32'h100003) | 50'h87, 4'd8, 0, 0, 0, 64'h0);
    exp_tgt("R3 ignored bits", 0, 0, 32'h3);
    acc(1, haddr(2, 32'h100005), 4'd8, 64'hFEDC_BA98_7654_3210, 0, 0, 64'h0);
    exp_tgt("R3 write", 0, 0, 32'h5);
    chk("R3 wdata", r_wd, 64'hFEDC_BA98_7654_3210);
    chk("R3 write dir", 64'(r_wr), 64'(1));
    chk("R10 write rdata", r_data, 64'h0);
  endtask

  task automatic t_priority;
    acc(0, haddr(2, 32'h100009), 4'd8, 0, 0, 0, 64'h100);
    exp_tgt("R8 overlap low slot", 0, 0, 32'h9);
    acc(0, haddr(2, 32'h100010), 4'd8, 0, 0, 0, 64'h100);
    exp_tgt("R8 second slot", 1, 0, 32'h8);
    chk("R10 slot data", r_data, 64'h101);
    acc(0, haddr(2, 32'h300005), 4'd8, 0, 0, 0, 64'h100);
    exp_tgt("R8 low range", 1, 1, 32'h5);
    acc(0, haddr(2, 32'h200000), 4'd8, 0, 0, 0, 64'h100);
    exp_tgt("R7 zero size skipped", 1, 2, 32'h0);
  endtask

  task automatic t_bounds;
    acc(0, haddr(2, 32'h10000F), 4'd8, 0, 0, 0, 64'h0);
    exp_tgt("R7 last of slot0", 0, 0, 32'hF);
    acc(0, haddr(2, 32'h100017), 4'd8, 0, 0, 0, 64'h0);
    exp_tgt("R7 last of slot1", 1, 0, 32'hF);
    acc(0, haddr(2, 32'h100018), 4'd8, 0, 0, 0, 64'h0);
    exp_local("R7 past end", 64'h0, 1);
    acc(0, haddr(2, 32'h40001F), 4'd8, 0, 0, 0, 64'h0);
    exp_tgt("R7 slot2 end", 2, 0, 32'h1F);
    acc(0, haddr(2, 32'h400020), 4'd8, 0, 0, 0, 64'h0);
    exp_local("R7 slot2 past", 64'h0, 1);
  endtask

  task automatic t_miss;
    acc(0, haddr(2, 32'h500000), 4'd8, 0, 0, 0, 64'h55);
    exp_local("R9 read miss", 64'h0, 1);
    acc(1, haddr(2, 32'h500000), 4'd8, 64'h9, 0, 0, 64'h0);
    exp_local("R9 write miss", 64'h0, 1);
  endtask

  task automatic t_nack;
    acc(0, haddr(2, 32'h100001), 4'd8, 0, 1, 0, 64'hCAFE);
    exp_tgt("R10 nack", 0, 0, 32'h1);
    chk("R10 nack fail", 64'(r_fail), 64'(1));
    chk("R10 nack done", 64'(r_done), 64'(1));
    chk("R10 nack data", r_data, 64'h0);
    chk("R12 nack latency", 64'(r_cyc), 64'(2));
  endtask

  task automatic t_window;
    acc(0, haddr(1, 32'h100001), 4'd8, 0, 0, 0, 64'h1);
    exp_local("R1 lower window", 64'h0, 1);
    acc(0, haddr(3, 32'h100001), 4'd8, 0, 0, 0, 64'h1);
    exp_local("R1 upper window", 64'h0, 1);
    acc(0, haddr(2, 32'h7FFFFFFF) | 50'h7, 4'd8, 0, 0, 0, 64'h1);
    exp_tgt("R1 last window word", 2, 1, 32'hF);
    acc(0, haddr(2, 32'h100001), 4'd4, 0, 0, 0, 64'h1);
    exp_local("R2 size 4", 64'h0, 1);
    acc(1, haddr(2, 32'h100001), 4'd0, 64'h3, 0, 0, 64'h1);
    exp_local("R2 size 0", 64'h0, 1);
    acc(0, haddr(2, 32'hF000F), 4'd2, 0, 0, 0, 64'h1);
    exp_local("R2 bad size beats local", 64'h0, 1);
    chip_sel = 6'd5;
    acc(0, haddr(5, 32'hF000F), 4'd8, 0, 0, 0, 64'h1);
    exp_local("R1 other chip", ID_V, 0);
    chip_sel = 6'd2;
  endtask

  task automatic t_hold;
    acc(0, haddr(2, 32'h300002), 4'd8, 0, 0, 3, 64'h4000);
    exp_tgt("R11 delayed", 1, 1, 32'h2);
    chk("R11 req held", 64'(r_held_bad), 64'(0));
    chk("R11 host blocked", 64'(r_ready_bad), 64'(0));
    chk("R12 delayed latency", 64'(r_cyc), 64'(5));
    chk("R10 delayed data", r_data, 64'h4001);
  endtask

  initial begin
    set_rng(0, 0, 32'h100000, 32'h10);
    set_rng(0, 1, 32'h200000, 32'h0);
    set_rng(0, 2, 32'h2013F00, 32'h10);
    set_rng(0, 3, 32'h1010C00, 32'h8);
    set_rng(1, 0, 32'h100008, 32'h10);
    set_rng(1, 1, 32'h300000, 32'h100);
    set_rng(1, 2, 32'h200000, 32'h4);
    set_rng(1, 3, 32'h300000, 32'h10);
    set_rng(2, 0, 32'h400000, 32'h20);
    set_rng(2, 1, 32'h7FFFFFF0, 32'h10);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_id();
    t_zero_reads();
    t_discard_writes();
    t_xlate();
    t_priority();
    t_bounds();
    t_miss();
    t_nack();
    t_window();
    t_hold();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R12 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule